// File: doc/BRIEF.md
# Four-Phase Process Handshake Controller

This block sequences a single datapath operation, such as one addition on a shared ALU, for a parent sequencer. The parent raises a start request. The controller then works through the operation in order. It first requests both source operands at the same time so that the two source multiplexers select together. It then requests the functional unit and waits for that unit's acknowledge. Next it requests the destination-register write and waits for that acknowledge. Only then does it acknowledge the parent.

After the working phase comes a return-to-zero idling phase. All datapath requests are withdrawn together. The start acknowledge is held until the parent has dropped its request and both datapath acknowledges have returned low.

The asynchronous event order is reproduced with a clocked state machine. Every handshake input is sampled on the rising clock edge, and every output is registered. An acknowledge is taken as valid only after it has been seen low while its request was pending. A stale or early acknowledge therefore cannot move the sequence forward. The functional-unit and register-write acknowledges are bundled-delay returns. The external delay on the functional-unit acknowledge must cover the worst operand fetch, the worst unit delay and the worst destination-multiplexer delay. The delay on the write acknowledge must cover the worst register write.

Top module: `proc_hs_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `src_req`, `unit_req`, `wb_req` and `go_ack` are all 0.
- R2: When `go_req` is sampled 1 in the idle state, every bit of `src_req` rises together on that clock edge, and `unit_req` is still 0 in the following cycle.
- R3: `unit_req` rises on the edge after `src_req` went high, but only on an edge where `unit_ack` is sampled 0. While `unit_ack` is held high before `unit_req` rises, `unit_req` stays 0.
- R4: `wb_req` rises on the first edge where `unit_ack` is sampled 1 and `wb_ack` is sampled 0. A `wb_ack` that is high before `wb_req` rises holds `wb_req` at 0.
- R5: `go_ack` rises on the first edge where `wb_ack` is sampled 1 while `wb_req` is high. With acknowledge delays of F and W cycles, `go_ack` is seen F+W+2 cycles after `go_req` is raised.
- R6: One cycle after `go_ack` rises, `src_req`, `unit_req` and `wb_req` are all 0, while `go_ack` stays 1.
- R7: `go_ack` falls only on an edge where `go_req`, `unit_ack` and `wb_ack` are all sampled 0. While any of them is high, `go_ack` stays 1.
- R8: During the working phase the requests accumulate. Each snapshot {src_req, unit_req, wb_req, go_ack} takes the values 11000, 11100, 11110, 11111, 00001 and 00000 in that order, with no other value in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| go_req | input | 1 | Start request from the parent sequencer |
| go_ack | output | 1 | Start acknowledge to the parent sequencer |
| src_req | output | N_SRC | Operand-fetch requests, one per source multiplexer |
| unit_req | output | 1 | Functional-unit request |
| unit_ack | input | 1 | Functional-unit acknowledge (bundled delay) |
| wb_req | output | 1 | Destination-register write request |
| wb_ack | input | 1 | Destination-register write acknowledge (bundled delay) |

## Verification
The hardest cases to reach are the out-of-order ones. In these, an acknowledge is already high before its request, or it lingers after the parent has withdrawn. A well-behaved datapath model never produces either. The bench model therefore has override flags that hold `unit_ack` or `wb_ack` high independently of the request. The stimulus raises these flags before starting a transaction, or keeps them up after `go_req` falls. It then checks that the outputs stay frozen and that the sequence resumes in the expected order once the flag is released. Different acknowledge delays, and different hold times on `go_req`, vary the spacing of the working and idling phases.

// File: rtl/hs_pkg.sv
package hs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_UNIT  = 3'd2,
    ST_WRITE = 3'd3,
    ST_DONE  = 3'd4,
    ST_RTZ   = 3'd5
  } hs_state_t;

endpackage

// File: rtl/hs_seq_fsm.sv
module hs_seq_fsm
  import hs_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      go_req,
  input  logic      unit_ack,
  input  logic      wb_ack,
  output hs_state_t state_q,
  output hs_state_t state_d
);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (go_req)                state_d = ST_FETCH;
      // an acknowledge already high counts as stale: wait for it to clear
      ST_FETCH: if (!unit_ack)             state_d = ST_UNIT;
      ST_UNIT:  if (unit_ack && !wb_ack)   state_d = ST_WRITE;
      ST_WRITE: if (wb_ack)                state_d = ST_DONE;
      ST_DONE:                             state_d = ST_RTZ;
      ST_RTZ:   if (!go_req && !unit_ack && !wb_ack) state_d = ST_IDLE;
      default:                             state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

endmodule

// File: rtl/hs_out_reg.sv
module hs_out_reg
  import hs_pkg::*;
#(
  parameter int N_SRC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  hs_state_t        state_d,
  output logic [N_SRC-1:0] src_req,
  output logic             unit_req,
  output logic             wb_req,
  output logic             go_ack
);

  logic src_on, unit_on, wb_on, ack_on;

  always_comb begin
    src_on  = (state_d == ST_FETCH) || (state_d == ST_UNIT) ||
              (state_d == ST_WRITE) || (state_d == ST_DONE);
    unit_on = (state_d == ST_UNIT) || (state_d == ST_WRITE) ||
              (state_d == ST_DONE);
    wb_on   = (state_d == ST_WRITE) || (state_d == ST_DONE);
    ack_on  = (state_d == ST_DONE) || (state_d == ST_RTZ);
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) src_req[i] <= 1'b0;
      else     src_req[i] <= src_on;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      unit_req <= 1'b0;
      wb_req   <= 1'b0;
      go_ack   <= 1'b0;
    end else begin
      unit_req <= unit_on;
      wb_req   <= wb_on;
      go_ack   <= ack_on;
    end
  end

endmodule

// File: rtl/proc_hs_ctrl.sv
module proc_hs_ctrl
  import hs_pkg::*;
#(
  parameter int N_SRC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go_req,
  output logic             go_ack,
  output logic [N_SRC-1:0] src_req,
  output logic             unit_req,
  input  logic             unit_ack,
  output logic             wb_req,
  input  logic             wb_ack
);

  hs_state_t state_q, state_d;

  hs_seq_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .go_req   (go_req),
    .unit_ack (unit_ack),
    .wb_ack   (wb_ack),
    .state_q  (state_q),
    .state_d  (state_d)
  );

  hs_out_reg #(.N_SRC(N_SRC)) u_out (
    .clk      (clk),
    .rst      (rst),
    .state_d  (state_d),
    .src_req  (src_req),
    .unit_req (unit_req),
    .wb_req   (wb_req),
    .go_ack   (go_ack)
  );

endmodule

// File: rtl/hs_ctrl_chk.sv
module hs_ctrl_chk #(
  parameter int N_SRC = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             go_req,
  input logic             go_ack,
  input logic [N_SRC-1:0] src_req,
  input logic             unit_req,
  input logic             unit_ack,
  input logic             wb_req,
  input logic             wb_ack
);

  always @(posedge clk) begin
    if (rst) begin
      AST_RESET_QUIET: assert (!go_ack) else $error("go_ack high under reset"); // R1
    end
  end

  AST_SRC_TOGETHER: assert property (@(posedge clk) disable iff (rst)
    ($countones(src_req) == 0) || ($countones(src_req) == N_SRC)); // R2

  AST_UNIT_ORDER: assert property (@(posedge clk) disable iff (rst)
    $rose(unit_req) |-> (!$past(unit_ack) && (&src_req))); // R3

  AST_WB_ORDER: assert property (@(posedge clk) disable iff (rst)
    $rose(wb_req) |-> ($past(unit_ack) && !$past(wb_ack) && unit_req)); // R4

  AST_ACK_AFTER_WB: assert property (@(posedge clk) disable iff (rst)
    $rose(go_ack) |-> ($past(wb_ack) && wb_req)); // R5

  AST_RTZ_ALL: assert property (@(posedge clk) disable iff (rst)
    $rose(go_ack) |=> (!unit_req && !wb_req && (src_req == '0) && go_ack)); // R6

  AST_ACK_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(go_ack) |-> (!$past(go_req) && !$past(unit_ack) && !$past(wb_ack))); // R7

  AST_NESTED_REQ: assert property (@(posedge clk) disable iff (rst)
    (wb_req |-> unit_req) and (unit_req |-> (&src_req))); // R8

endmodule

bind proc_hs_ctrl hs_ctrl_chk #(.N_SRC(N_SRC)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .go_req   (go_req),
  .go_ack   (go_ack),
  .src_req  (src_req),
  .unit_req (unit_req),
  .unit_ack (unit_ack),
  .wb_req   (wb_req),
  .wb_ack   (wb_ack)
);

// File: tb/test_proc_hs_ctrl.sv
module test_proc_hs_ctrl;

  localparam int N_SRC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic go_req = 1'b0;
  logic go_ack, unit_req, wb_req;
  logic [N_SRC-1:0] src_req;
  logic unit_ack, wb_ack;

  logic unit_ack_r = 1'b0, wb_ack_r = 1'b0;
  logic unit_stale = 1'b0, wb_stale = 1'b0;
  int   unit_dly = 1, wb_dly = 1;
  int   unit_cnt = 0, wb_cnt = 0;
  int   total = 0, bad = 0;
  int   cyc = 0;
  logic [4:0] expq[$];
  logic [4:0] prev_snap;
  logic mon_on = 1'b0;

  assign unit_ack = unit_ack_r | unit_stale;
  assign wb_ack   = wb_ack_r | wb_stale;

  always #2 clk = ~clk;

  proc_hs_ctrl #(.N_SRC(N_SRC)) i_proc_hs_ctrl (
    .clk(clk), .rst(rst), .go_req(go_req), .go_ack(go_ack),
    .src_req(src_req), .unit_req(unit_req), .unit_ack(unit_ack),
    .wb_req(wb_req), .wb_ack(wb_ack)
  );

  function automatic logic [4:0] snap();
    return {src_req, unit_req, wb_req, go_ack};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // datapath model: bundled-delay acknowledges
  always @(negedge clk) begin
    if (unit_req && !unit_ack_r) begin
      unit_cnt++;
      if (unit_cnt >= unit_dly) unit_ack_r = 1'b1;
    end else if (!unit_req) begin
      unit_cnt = 0; unit_ack_r = 1'b0;
    end
    if (wb_req && !wb_ack_r) begin
      wb_cnt++;
      if (wb_cnt >= wb_dly) wb_ack_r = 1'b1;
    end else if (!wb_req) begin
      wb_cnt = 0; wb_ack_r = 1'b0;
    end
  end

  // scoreboard monitor (R8)
  always @(negedge clk) begin
    if (mon_on && snap() != prev_snap) begin
      if (expq.size() == 0) check("R8 unexpected change", {27'd0, snap()}, {27'd0, prev_snap});
      else check("R8 order", {27'd0, snap()}, {27'd0, expq.pop_front()});
      prev_snap = snap();
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic txn(input int fd, input int wd, input int hold, input bit timed);
    int k;
    unit_dly = fd; wb_dly = wd;
    expq.push_back(5'b11000); expq.push_back(5'b11100);
    expq.push_back(5'b11110); expq.push_back(5'b11111);
    expq.push_back(5'b00001); expq.push_back(5'b00000);
    @(negedge clk);
    go_req = 1'b1;
    k = 0;
    @(negedge clk); k++;
    if (timed) begin
      check("R2 src_req together", {30'd0, src_req}, 32'h3);
      check("R2 unit_req still low", {31'd0, unit_req}, 32'h0);
    end
    while (!go_ack) begin @(negedge clk); k++; end
    if (timed) check("R5 ack latency", k, fd + wd + 2);
    @(negedge clk);
    check("R6 requests withdrawn", {27'd0, snap()}, 32'h01);
    wait_cyc(hold);
    check("R7 ack held while go_req high", {31'd0, go_ack}, 32'h1);
    go_req = 1'b0;
    while (go_ack) @(negedge clk);
    wait_cyc(2);
  endtask

  initial begin
    wait_cyc(3);
    check("R1 reset outputs", {27'd0, snap()}, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", {27'd0, snap()}, 32'h0);
    prev_snap = snap();
    mon_on = 1'b1;

    txn(1, 1, 0, 1'b1);
    txn(3, 2, 4, 1'b1);
    txn(6, 5, 1, 1'b1);

    // R3: stale unit_ack blocks unit_req
    unit_stale = 1'b1;
    fork
      txn(2, 2, 0, 1'b0);
      begin
        wait_cyc(6);
        check("R3 unit_req held by stale ack", {31'd0, unit_req}, 32'h0);
        check("R3 src_req up", {30'd0, src_req}, 32'h3);
        unit_stale = 1'b0;
      end
    join

    // R4: stale wb_ack blocks wb_req
    wb_stale = 1'b1;
    fork
      txn(2, 2, 0, 1'b0);
      begin
        wait_cyc(8);
        check("R4 wb_req held by stale ack", {31'd0, wb_req}, 32'h0);
        check("R4 unit_req up", {31'd0, unit_req}, 32'h1);
        wb_stale = 1'b0;
      end
    join

    // R7: lingering wb_ack keeps go_ack high after go_req falls
    unit_dly = 1; wb_dly = 1;
    expq.push_back(5'b11000); expq.push_back(5'b11100);
    expq.push_back(5'b11110); expq.push_back(5'b11111);
    expq.push_back(5'b00001); expq.push_back(5'b00000);
    @(negedge clk); go_req = 1'b1;
    while (!go_ack) @(negedge clk);
    wb_stale = 1'b1;
    go_req = 1'b0;
    wait_cyc(5);
    check("R7 ack held by wb_ack", {31'd0, go_ack}, 32'h1);
    check("R6 requests stay low", {29'd0, src_req, unit_req, wb_req}, 32'h0);
    wb_stale = 1'b0;
    wait_cyc(3);
    check("R7 ack released", {31'd0, go_ack}, 32'h0);

    txn(2, 7, 2, 1'b1);
    wait_cyc(3);
    check("R8 scoreboard drained", expq.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule